// File: doc/BRIEF.md
# Serial Entry-Key Detector

This block sits on the target side of a serial programming port and decides whether the device may switch into program/verify mode. It watches three inputs, all already synchronised to the system clock: an enable line, a serial clock and a serial data line. A key window opens only after the enable line has been pulsed high and brought low again. Inside the window the detector samples the data line on each rising edge of the serial clock and collects exactly 32 bits, most significant bit first. The collected word is then compared with a fixed key.

When the key matches, the detector waits for the enable line to be raised again. From then on it reports program mode and drives a request that places unused I/O in high impedance. A separate data-valid output stays low for a parameterised guard period, so that anything the host sends too early is not taken as valid. If the enable line drops at any point, program mode ends, and the collected key and the bit count are discarded.

Top module: `keyentry_detector`

## Requirements
- R1: After reset, progMode, ioHighZ and dataValid are all 0 and no key window is open.
- R2: Serial clock edges are collected only after enableIn has been high and then low. If no such pulse came first, a correct key does not lead to entry when enableIn is later raised.
- R3: serData is sampled on each rising edge of serClk while the window is open, and the first sample is key bit 31. If the 32 collected bits equal 32'h4D434850, a later rise of enableIn leads to entry.
- R4: If any one of the 32 collected bits differs from the key, no entry happens. The detector goes back to idle.
- R5: Only the first 32 rising edges are collected. Further edges before enableIn rises change neither the key nor the outcome.
- R6: If enableIn rises before 32 bits have been collected, the collection is abandoned and no entry happens. That high phase counts as the opening pulse of a new window once enableIn falls again.
- R7: After a matching key, progMode and ioHighZ read 1 from the first clock edge that samples enableIn high. ioHighZ always equals progMode.
- R8: dataValid stays 0 during the first GUARD_CYCLES cycles in which progMode is 1, and reads 1 from the next cycle for as long as program mode lasts.
- R9: When enableIn goes low, progMode, ioHighZ and dataValid read 0 after the next clock edge. The key and the bit count are cleared, so a new entry needs a new pulse and a full key.
- R10: A serClk level held high over many system clocks counts as a single edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enableIn | input | 1 | Synchronised enable line that opens the key window and holds program mode |
| serClk | input | 1 | Synchronised serial clock; data is sampled on its rising edge |
| serData | input | 1 | Synchronised serial data, most significant bit first |
| progMode | output | 1 | Program/verify mode active |
| ioHighZ | output | 1 | Request to place unused I/O in high impedance |
| dataValid | output | 1 | Serial data may be interpreted (guard period over) |

## Verification
The hardest situation to reach is a key window that opens without a deliberate pulse. This happens after an abandoned or failed collection, when the high phase that ended it becomes the opening pulse for the next attempt. The bench keeps a small model of whether a window is open across sessions. Its random sessions mix short aborted keys, single-bit flips, random words and correct keys, with and without a leading pulse. This steers the design into the case where a session with no pulse still succeeds, and into the case where a closed window after a successful exit blocks a correct key.

// File: rtl/keyentry_pkg.sv
package keyentry_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,    // waiting for enable high
    ST_ARMED,   // enable high, waiting for it to fall
    ST_SHIFT,   // collecting key bits
    ST_HOLD,    // key matched, waiting for enable high
    ST_GUARD,   // program mode, guard delay running
    ST_ACTIVE   // program mode, data valid
  } entryState_t;

  typedef struct packed {
    logic clearAll;  // discard key register and bit count
    logic shiftEn;   // allow serial edges to be collected
    logic guardRun;  // run the guard counter
  } dpStrobe_t;

endpackage

// File: rtl/keyentry_datapath.sv
module keyentry_datapath
  import keyentry_pkg::*;
#(
  parameter int KEY_WIDTH    = 32,
  parameter logic [KEY_WIDTH-1:0] KEY_VALUE = 32'h4D434850,
  parameter int GUARD_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serClk,
  input  logic       serData,
  input  dpStrobe_t  strobe,
  output logic       bitsFull,
  output logic       keyMatch,
  output logic       guardDone
);

  localparam int CNT_W   = $clog2(KEY_WIDTH + 1);
  localparam int GUARD_W = (GUARD_CYCLES > 1) ? $clog2(GUARD_CYCLES + 1) : 1;

  logic                 sclkPrev;
  logic                 sclkRise;
  logic [KEY_WIDTH-1:0] keyReg;
  logic [CNT_W-1:0]     bitCnt;
  logic [GUARD_W-1:0]   guardCnt;

  // Rising-edge detect; reset high so a line already high is not an edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b1;
    else       sclkPrev <= serClk;
  end

  assign sclkRise = serClk && !sclkPrev;
  assign bitsFull = (bitCnt == CNT_W'(KEY_WIDTH));
  assign keyMatch = (keyReg == KEY_VALUE);

  // Key shift register and bit counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyReg <= '0;
      bitCnt <= '0;
    end else if (strobe.clearAll) begin
      keyReg <= '0;
      bitCnt <= '0;
    end else if (strobe.shiftEn && sclkRise && !bitsFull) begin
      keyReg <= {keyReg[KEY_WIDTH-2:0], serData};
      bitCnt <= bitCnt + 1'b1;
    end
  end

  // Guard delay counter.
  assign guardDone = (guardCnt == GUARD_W'(GUARD_CYCLES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 guardCnt <= '0;
    else if (!strobe.guardRun) guardCnt <= '0;
    else if (!guardDone)       guardCnt <= guardCnt + 1'b1;
  end

endmodule

// File: rtl/keyentry_control.sv
module keyentry_control
  import keyentry_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enableIn,
  input  logic       bitsFull,
  input  logic       keyMatch,
  input  logic       guardDone,
  output dpStrobe_t  strobe,
  output logic       progMode,
  output logic       ioHighZ,
  output logic       dataValid
);

  entryState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (enableIn) stateNext = ST_ARMED;
      ST_ARMED:  if (!enableIn) stateNext = ST_SHIFT;
      ST_SHIFT: begin
        if (bitsFull)      stateNext = keyMatch ? ST_HOLD : ST_IDLE;
        else if (enableIn) stateNext = ST_IDLE;
      end
      ST_HOLD:   if (enableIn) stateNext = ST_GUARD;
      ST_GUARD: begin
        if (!enableIn)      stateNext = ST_IDLE;
        else if (guardDone) stateNext = ST_ACTIVE;
      end
      ST_ACTIVE: if (!enableIn) stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.clearAll = (state == ST_IDLE) || (state == ST_ARMED);
    strobe.shiftEn  = (state == ST_SHIFT);
    strobe.guardRun = (state == ST_GUARD);
  end

  assign progMode  = (state == ST_GUARD) || (state == ST_ACTIVE);
  assign ioHighZ   = progMode;
  assign dataValid = (state == ST_ACTIVE);

endmodule

// File: rtl/keyentry_detector.sv
module keyentry_detector
  import keyentry_pkg::*;
#(
  parameter int KEY_WIDTH    = 32,
  parameter logic [KEY_WIDTH-1:0] KEY_VALUE = 32'h4D434850,
  parameter int GUARD_CYCLES = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic enableIn,
  input  logic serClk,
  input  logic serData,
  output logic progMode,
  output logic ioHighZ,
  output logic dataValid
);

  dpStrobe_t strobe;
  logic      bitsFull;
  logic      keyMatch;
  logic      guardDone;

  keyentry_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .enableIn  (enableIn),
    .bitsFull  (bitsFull),
    .keyMatch  (keyMatch),
    .guardDone (guardDone),
    .strobe    (strobe),
    .progMode  (progMode),
    .ioHighZ   (ioHighZ),
    .dataValid (dataValid)
  );

  keyentry_datapath #(
    .KEY_WIDTH    (KEY_WIDTH),
    .KEY_VALUE    (KEY_VALUE),
    .GUARD_CYCLES (GUARD_CYCLES)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .serClk    (serClk),
    .serData   (serData),
    .strobe    (strobe),
    .bitsFull  (bitsFull),
    .keyMatch  (keyMatch),
    .guardDone (guardDone)
  );

endmodule

// File: rtl/keyentry_checker.sv
module keyentry_checker #(
  parameter int GUARD_CYCLES = 16
) (
  input logic clk,
  input logic rstN,
  input logic enableIn,
  input logic serClk,
  input logic serData,
  input logic progMode,
  input logic ioHighZ,
  input logic dataValid
);

  logic [31:0] guardSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           guardSeen <= '0;
    else if (!progMode)  guardSeen <= '0;
    else if (!dataValid) guardSeen <= guardSeen + 1'b1;
  end

  // R7: program mode begins only on a cycle after enable was seen high
  a_r7_mode_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(progMode) |-> $past(enableIn));

  // R9: a low enable ends program mode at the next edge
  a_r9_drop_exits: assert property (@(posedge clk) disable iff (!rstN)
    !enableIn |=> (!progMode && !dataValid && !ioHighZ));

  // R8: data valid only inside program mode
  a_r8_valid_in_mode: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> progMode);

  // R8: guard period lasts exactly GUARD_CYCLES cycles
  a_r8_guard_length: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataValid) |-> (guardSeen == 32'(GUARD_CYCLES)));

  logic unusedInputs;
  assign unusedInputs = serClk ^ serData;

endmodule

bind keyentry_detector keyentry_checker #(.GUARD_CYCLES(GUARD_CYCLES)) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .enableIn  (enableIn),
  .serClk    (serClk),
  .serData   (serData),
  .progMode  (progMode),
  .ioHighZ   (ioHighZ),
  .dataValid (dataValid)
);

// File: tb/keyentry_detector_test.sv
`timescale 1ns/1ps
module keyentry_detector_test;

  localparam int          GUARD = 16;
  localparam logic [31:0] KEY   = 32'h4D434850;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enableIn = 1'b0;
  logic serClk = 1'b0;
  logic serData = 1'b0;
  logic progMode, ioHighZ, dataValid;

  int checks = 0;
  int fails = 0;
  bit windowOpen = 1'b0;   // bench model: key window open

  always #4 clk = ~clk;    // 125 MHz

  keyentry_detector #(.GUARD_CYCLES(GUARD)) uut (
    .clk(clk), .rstN(rstN), .enableIn(enableIn), .serClk(serClk),
    .serData(serData), .progMode(progMode), .ioHighZ(ioHighZ),
    .dataValid(dataValid)
  );

  task automatic check(input logic actual, input logic expected, input string req);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, actual, expected, $time);
    end
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Send n bits of w, starting at bit 31; serClk high held for 3 cycles.
  task automatic sendBits(input logic [31:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      serData = w[31 - i];
      serClk  = 1'b0;
      waitCycles(2);
      serClk  = 1'b1;
      waitCycles(3);
    end
    serClk = 1'b0;
    waitCycles(1);
  endtask

  function automatic bit expectEntry(input bit open, input logic [31:0] w, input int n);
    return open && (n == 32) && (w == KEY);
  endfunction

  task automatic session(input bit pulse, input logic [31:0] w, input int n,
                         input logic [31:0] extra, input int nExtra, input string tag);
    bit exp;
    enableIn = 1'b0;
    serClk   = 1'b0;
    waitCycles(2);
    if (pulse) begin
      enableIn = 1'b1;
      waitCycles(2);
      enableIn = 1'b0;
      waitCycles(2);
      windowOpen = 1'b1;
    end
    sendBits(w, n);
    if (nExtra > 0) sendBits(extra, nExtra);
    waitCycles(3);
    exp = expectEntry(windowOpen, w, n);
    enableIn = 1'b1;
    waitCycles(1);
    check(progMode, exp, {tag, " R7 mode on enable rise"});
    check(ioHighZ, exp, {tag, " R7 highz follows mode"});
    waitCycles(GUARD - 1);
    check(dataValid, 1'b0, {tag, " R8 guard holds data invalid"});
    waitCycles(1);
    check(dataValid, exp, {tag, " R8 data valid after guard"});
    check(progMode, exp, {tag, " R3 entry outcome"});
    enableIn = 1'b0;
    waitCycles(1);
    check(progMode | ioHighZ | dataValid, 1'b0, {tag, " R9 exit on enable low"});
    windowOpen = !exp;  // the raise/drop reopens a window unless entry consumed it
  endtask

  initial begin
    logic [31:0] w;
    int kind, n, nExtra;
    bit pulse;
    void'($urandom(32'd20240611));
    waitCycles(3);
    check(progMode, 1'b0, "R1 reset progMode");
    check(ioHighZ, 1'b0, "R1 reset ioHighZ");
    check(dataValid, 1'b0, "R1 reset dataValid");
    @(negedge clk) rstN = 1'b1;
    waitCycles(2);

    session(1'b0, KEY, 32, 32'h0, 0, "R2 no pulse");
    session(1'b1, KEY, 32, 32'h0, 0, "R3 good key");
    session(1'b1, KEY ^ 32'h1, 32, 32'h0, 0, "R4 lsb flip");
    session(1'b1, KEY ^ 32'h8000_0000, 32, 32'h0, 0, "R4 msb flip");
    session(1'b1, KEY, 32, 32'hFFFF_FFFF, 7, "R5 extra edges");
    session(1'b1, KEY, 31, 32'h0, 0, "R6 abort short");
    session(1'b0, KEY, 32, 32'h0, 0, "R6 reopened window");
    session(1'b0, KEY, 32, 32'h0, 0, "R9 closed after exit");
    session(1'b1, KEY, 32, 32'h0, 0, "R10 held clock level");

    for (int s = 0; s < 40; s++) begin
      pulse  = ($urandom % 4) != 0;
      kind   = $urandom % 4;
      n      = 32;
      nExtra = 0;
      case (kind)
        0: w = KEY;
        1: w = KEY ^ (32'h1 << ($urandom % 32));
        2: w = $urandom;
        default: begin w = KEY; n = 1 + ($urandom % 31); end
      endcase
      if (n == 32) nExtra = $urandom % 6;
      session(pulse, w, n, $urandom, nExtra, "R3 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule